// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block sits on the device side of a synchronous DRAM interface. On each rising clock edge it samples chip select, the three strobes (RAS, CAS, WE), clock enable and the address lines. It turns them into one command code and gives the address lines the meaning that command assigns to them: row, column, bank, auto-precharge request or "close all banks". It keeps an open or closed flag for each of the two banks. It holds the mode register and checks its latency field. It raises a one-cycle error pulse for a command that breaks an ordering rule.

All outputs are registered. The result for a command sampled at clock edge k appears just after edge k, and the bank flags then show the state after that command. The block has no memory array, no data path and no power state machine. A downstream array model or protocol monitor consumes its decoded stream.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: While reset is high, both banks are marked closed. The mode register clears to zero, which is an invalid latency. The command output reads NOP (code 0) and the error pulse is low.
- R2: With chip select low, {RAS,CAS,WE} decodes as follows: 111 NOP (0), 011 activate (2), 101 read (3), 100 write (4), 010 precharge (5), 110 burst stop (6), 001 auto refresh (7) if clock enable is high or self refresh (8) if it is low, and 000 mode set (9).
- R3: With chip select high, the command output is deselect (1). Bank flags and the mode register do not change, and no error is raised.
- R4: Activate opens the bank given by the top address bit (0 = bank 0, 1 = bank 1), and the row output carries address bits 10:0. An activate to a bank that is already open raises the error and leaves both bank flags unchanged.
- R5: Read and write report the bank from the top address bit and the column from address bits 7:0. A read or write to a closed bank raises the error.
- R6: Read and write set the auto-precharge output to address bit 10. A legal read or write with bit 10 set leaves its bank closed for the commands that follow.
- R7: Precharge with address bit 10 set closes both banks, whatever the bank bit. With bit 10 clear, it closes only the bank that the top address bit selects. Precharge never raises the error.
- R8: Mode set stores the whole address into the mode register only while both banks are closed. Otherwise it raises the error and the register keeps its value.
- R9: The mode is valid only when mode bits 6:4 hold 010 (latency 2) or 011 (latency 3). While the mode is invalid, activate, read and write raise the error and change no bank flag.
- R10: Auto refresh and self refresh raise the error when either bank is open. No bank address is used and no flag changes.
- R11: The error is high only in the cycle that follows an illegal command. NOP, deselect, burst stop and precharge never raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable; selects self refresh over auto refresh |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Address lines; the top bit is the bank select |
| cmd_o | output | 4 | Decoded command code |
| bank_o | output | 1 | Bank bit of the last selected command |
| row_o | output | ROW_W | Row address of the last selected command |
| col_o | output | COL_W | Column address of the last selected command |
| auto_pre_o | output | 1 | Auto-precharge request on read or write |
| mode_o | output | ADDR_W | Mode register contents |
| mode_valid_o | output | 1 | Mode register holds a legal latency |
| err_o | output | 1 | One-cycle pulse flagging an illegal command |
| bank_open_o | output | 2 | Open flag per bank |

## Verification
The bench uses the default parameters: a 12-bit address, 11-bit rows and 8-bit columns. At that size every control combination can be swept in full. The sweep covers all sixteen chip select and strobe codes, both clock enable levels, both values of the bank bit and the precharge-all bit, and three latency field patterns (two legal, one reserved). It applies them from each reachable tracker state: mode invalid with banks closed, and mode valid with each of the four bank flag combinations. Each vector is compared against a model written from the requirements, so every pairing of command with bank state is reached, including mode set and refresh while banks are open.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;

    localparam int NBANK = 2;

    typedef enum logic [3:0] {
        CMD_NOP   = 4'd0,
        CMD_DESEL = 4'd1,
        CMD_ACT   = 4'd2,
        CMD_RD    = 4'd3,
        CMD_WR    = 4'd4,
        CMD_PRE   = 4'd5,
        CMD_BST   = 4'd6,
        CMD_AREF  = 4'd7,
        CMD_SREF  = 4'd8,
        CMD_MRS   = 4'd9
    } cmd_e;

    typedef struct packed {
        cmd_e cmd;
        logic bank;   // top address bit
        logic a10;    // auto-precharge / precharge-all bit
    } req_t;

    localparam logic [2:0] LAT_TWO   = 3'b010;
    localparam logic [2:0] LAT_THREE = 3'b011;

    function automatic cmd_e decode_cmd(input logic cs_n, input logic ras_n,
                                        input logic cas_n, input logic we_n,
                                        input logic cke);
        cmd_e c;
        if (cs_n) begin
            c = CMD_DESEL;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b111:  c = CMD_NOP;
                3'b011:  c = CMD_ACT;
                3'b101:  c = CMD_RD;
                3'b100:  c = CMD_WR;
                3'b010:  c = CMD_PRE;
                3'b110:  c = CMD_BST;
                3'b001:  c = cke ? CMD_AREF : CMD_SREF;
                default: c = CMD_MRS;
            endcase
        end
        return c;
    endfunction

    function automatic logic latency_legal(input logic [2:0] f);
        return (f == LAT_TWO) || (f == LAT_THREE);
    endfunction

endpackage

// File: rtl/sdram_cmd_classify.sv
module sdram_cmd_classify
    import sdram_trk_pkg::*;
(
    input  logic cke,
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic bank_bit,
    input  logic a10_bit,
    output req_t req
);
    always_comb begin
        req.cmd  = decode_cmd(cs_n, ras_n, cas_n, we_n, cke);
        req.bank = bank_bit;
        req.a10  = a10_bit;
    end
endmodule

// File: rtl/sdram_bank_state.sv
module sdram_bank_state #(
    parameter int NB = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NB-1:0] open_req,
    input  logic [NB-1:0] close_req,
    output logic [NB-1:0] open_q
);
    for (genvar b = 0; b < NB; b++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst)
                open_q[b] <= 1'b0;
            else if (close_req[b])
                open_q[b] <= 1'b0;
            else if (open_req[b])
                open_q[b] <= 1'b1;
        end
    end
endmodule

// File: rtl/sdram_mode_reg.sv
module sdram_mode_reg
    import sdram_trk_pkg::*;
#(
    parameter int MODE_W = 12,
    parameter int LAT_LSB = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [MODE_W-1:0] wr_data,
    output logic [MODE_W-1:0] mode_q,
    output logic              valid
);
    localparam int LAT_MSB = LAT_LSB + 2;

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= '0;
        else if (wr_en)
            mode_q <= wr_data;
    end

    assign valid = latency_legal(mode_q[LAT_MSB:LAT_LSB]);
endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
    import sdram_trk_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int ROW_W   = 11,
    parameter int COL_W   = 8,
    parameter int LAT_LSB = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cke,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [3:0]        cmd_o,
    output logic              bank_o,
    output logic [ROW_W-1:0]  row_o,
    output logic [COL_W-1:0]  col_o,
    output logic              auto_pre_o,
    output logic [ADDR_W-1:0] mode_o,
    output logic              mode_valid_o,
    output logic              err_o,
    output logic [NBANK-1:0]  bank_open_o
);
    localparam int BANK_BIT = ADDR_W - 1;
    localparam int A10_BIT  = ADDR_W - 2;

    req_t             req;
    logic [NBANK-1:0] open_req, close_req, open_q;
    logic             mode_wr, mode_ok, illegal, any_open;
    logic [ADDR_W-1:0] mode_q;

    sdram_cmd_classify u_classify (
        .cke      (cke),
        .cs_n     (cs_n),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_n     (we_n),
        .bank_bit (addr[BANK_BIT]),
        .a10_bit  (addr[A10_BIT]),
        .req      (req)
    );

    sdram_bank_state #(.NB(NBANK)) u_banks (
        .clk       (clk),
        .rst       (rst),
        .open_req  (open_req),
        .close_req (close_req),
        .open_q    (open_q)
    );

    sdram_mode_reg #(.MODE_W(ADDR_W), .LAT_LSB(LAT_LSB)) u_mode (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (mode_wr),
        .wr_data (addr),
        .mode_q  (mode_q),
        .valid   (mode_ok)
    );

    assign any_open = |open_q;

    // Legality and state updates for the sampled command
    always_comb begin
        open_req  = '0;
        close_req = '0;
        mode_wr   = 1'b0;
        illegal   = 1'b0;
        unique case (req.cmd)
            CMD_ACT: begin
                illegal = !mode_ok || open_q[req.bank];
                if (!illegal) open_req[req.bank] = 1'b1;
            end
            CMD_RD, CMD_WR: begin
                illegal = !mode_ok || !open_q[req.bank];
                if (!illegal && req.a10) close_req[req.bank] = 1'b1;
            end
            CMD_PRE: begin
                if (req.a10) close_req = '1;
                else         close_req[req.bank] = 1'b1;
            end
            CMD_AREF, CMD_SREF: illegal = any_open;
            CMD_MRS: begin
                illegal = any_open;
                mode_wr = !any_open;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_o      <= CMD_NOP;
            bank_o     <= 1'b0;
            row_o      <= '0;
            col_o      <= '0;
            auto_pre_o <= 1'b0;
            err_o      <= 1'b0;
        end else begin
            cmd_o      <= req.cmd;
            err_o      <= illegal;
            auto_pre_o <= (req.cmd == CMD_RD || req.cmd == CMD_WR) && req.a10;
            if (req.cmd != CMD_DESEL) begin
                bank_o <= req.bank;
                row_o  <= addr[ROW_W-1:0];
                col_o  <= addr[COL_W-1:0];
            end
        end
    end

    assign mode_o       = mode_q;
    assign mode_valid_o = mode_ok;
    assign bank_open_o  = open_q;
endmodule

// File: rtl/sdram_cmd_tracker_chk.sv
module sdram_cmd_tracker_chk
    import sdram_trk_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic              bank_sel,
    input logic              a10_bit,
    input logic [3:0]        cmd_o,
    input logic              err_o,
    input logic [1:0]        bank_open_o,
    input logic [ADDR_W-1:0] mode_o,
    input logic              mode_valid_o
);
    logic is_act, is_pre, is_mrs;
    assign is_act = !cs_n && !ras_n &&  cas_n &&  we_n;
    assign is_pre = !cs_n && !ras_n &&  cas_n && !we_n;
    assign is_mrs = !cs_n && !ras_n && !cas_n && !we_n;

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (bank_open_o == 2'b00 && !mode_valid_o && !err_o));

    assert_deselect_holds_R3: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> ($stable(bank_open_o) && $stable(mode_o) && !err_o && cmd_o == CMD_DESEL));

    assert_act_open_bank_R4: assert property (@(posedge clk) disable iff (rst)
        (is_act && bank_open_o[bank_sel]) |=> (err_o && $stable(bank_open_o)));

    assert_pre_all_R7: assert property (@(posedge clk) disable iff (rst)
        (is_pre && a10_bit) |=> (bank_open_o == 2'b00 && !err_o));

    assert_mode_locked_R8: assert property (@(posedge clk) disable iff (rst)
        (is_mrs && (|bank_open_o)) |=> (err_o && $stable(mode_o)));

    assert_err_source_R11: assert property (@(posedge clk) disable iff (rst)
        err_o |-> (cmd_o inside {CMD_ACT, CMD_RD, CMD_WR, CMD_AREF, CMD_SREF, CMD_MRS}));
endmodule

bind sdram_cmd_tracker sdram_cmd_tracker_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cs_n         (cs_n),
    .ras_n        (ras_n),
    .cas_n        (cas_n),
    .we_n         (we_n),
    .bank_sel     (addr[ADDR_W-1]),
    .a10_bit      (addr[ADDR_W-2]),
    .cmd_o        (cmd_o),
    .err_o        (err_o),
    .bank_open_o  (bank_open_o),
    .mode_o       (mode_o),
    .mode_valid_o (mode_valid_o)
);

// File: tb/sdram_cmd_tracker_tb.sv
module sdram_cmd_tracker_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cke = 1'b1;
    logic        cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [11:0] addr = '0;
    logic [3:0]  cmd_o;
    logic        bank_o, auto_pre_o, mode_valid_o, err_o;
    logic [10:0] row_o;
    logic [7:0]  col_o;
    logic [11:0] mode_o;
    logic [1:0]  bank_open_o;

    int vectors = 0;
    int fails   = 0;
    int cycles  = 0;

    // bench model state
    logic [1:0]  m_open;
    logic [11:0] m_mode;

    sdram_cmd_tracker u_dut (
        .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .addr(addr), .cmd_o(cmd_o),
        .bank_o(bank_o), .row_o(row_o), .col_o(col_o),
        .auto_pre_o(auto_pre_o), .mode_o(mode_o),
        .mode_valid_o(mode_valid_o), .err_o(err_o),
        .bank_open_o(bank_open_o)
    );

    always #5 clk = ~clk;

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
            summary();
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic lat_ok(input logic [11:0] m);
        return (m[6:4] == 3'b010) || (m[6:4] == 3'b011);
    endfunction

    // R1: reset state
    task automatic do_reset();
        rst = 1'b1; cs_n = 1'b0; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; cke = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R1 cmd", cmd_o, 0);
        chk("R1 err", err_o, 0);
        chk("R1 banks", bank_open_o, 0);
        chk("R1 mode_valid", mode_valid_o, 0);
        rst = 1'b0;
        m_open = 2'b00;
        m_mode = '0;
    endtask

    // Apply one command at a falling edge and check after the next rising edge
    task automatic step(input logic c, input logic [2:0] rcw, input logic ke,
                        input logic [11:0] a);
        int          ec;
        logic        ee, eap, b, a10;
        logic [1:0]  nopen;
        logic [11:0] nmode;
        cs_n = c; {ras_n, cas_n, we_n} = rcw; cke = ke; addr = a;
        b = a[11]; a10 = a[10];
        nopen = m_open; nmode = m_mode; ee = 1'b0; eap = 1'b0;
        if (c) ec = 1;
        else case (rcw)
            3'b111: ec = 0;
            3'b011: ec = 2;
            3'b101: ec = 3;
            3'b100: ec = 4;
            3'b010: ec = 5;
            3'b110: ec = 6;
            3'b001: ec = ke ? 7 : 8;
            default: ec = 9;
        endcase
        case (ec)
            2: begin
                ee = !lat_ok(m_mode) || m_open[b];
                if (!ee) nopen[b] = 1'b1;
            end
            3, 4: begin
                ee = !lat_ok(m_mode) || !m_open[b];
                eap = a10;
                if (!ee && a10) nopen[b] = 1'b0;
            end
            5: if (a10) nopen = 2'b00; else nopen[b] = 1'b0;
            7, 8: ee = |m_open;
            9: begin
                ee = |m_open;
                if (!ee) nmode = a;
            end
            default: ;
        endcase
        @(negedge clk);
        m_open = nopen; m_mode = nmode;
        chk(c ? "R3 cmd" : "R2 cmd", cmd_o, ec);
        if (ec == 7 || ec == 8) chk("R10 err", err_o, ee);
        else if (ec == 9)       chk("R8 err", err_o, ee);
        else if (ec == 2 || ec == 3 || ec == 4) chk("R9 R4 R5 err", err_o, ee);
        else                    chk("R11 err", err_o, ee);
        chk(ec == 5 ? "R7 banks" : (ec == 1 ? "R3 banks" : "R6 banks"), bank_open_o, m_open);
        chk(ec == 1 ? "R3 mode" : "R8 mode", mode_o, m_mode);
        chk("R9 mode_valid", mode_valid_o, lat_ok(m_mode));
        if (ec == 2) chk("R4 row", row_o, a[10:0]);
        if (ec == 3 || ec == 4) begin
            chk("R5 col", col_o, a[7:0]);
            chk("R5 bank", bank_o, b);
        end
        if (ec == 3 || ec == 4 || ec == 0) chk("R6 auto_pre", auto_pre_o, eap);
    endtask

    initial begin
        m_open = 2'b00;
        m_mode = '0;
        @(negedge clk);
        // states: 0 = mode invalid, 1..4 = mode valid with bank flags st-1
        for (int st = 0; st < 5; st++) begin
            for (int code = 0; code < 16; code++) begin
                for (int ke = 0; ke < 2; ke++) begin
                    for (int ab = 0; ab < 4; ab++) begin
                        for (int lt = 0; lt < 3; lt++) begin
                            logic [2:0]  lat;
                            logic [11:0] a;
                            do_reset();
                            if (st > 0) begin
                                step(1'b0, 3'b000, 1'b1, 12'h020);           // mode set, latency 2
                                if ((st - 1) & 1) step(1'b0, 3'b011, 1'b1, 12'h123);   // open bank 0
                                if ((st - 1) & 2) step(1'b0, 3'b011, 1'b1, 12'h8AB);   // open bank 1
                            end
                            lat = (lt == 0) ? 3'b010 : (lt == 1) ? 3'b011 : 3'b101;
                            a = {ab[1], ab[0], 3'b000, lat, 4'b0101};
                            step(code[3], code[2:0], ke[0], a);
                            // idle command afterwards: error must drop (R11)
                            step(1'b0, 3'b111, 1'b1, 12'h000);
                        end
                    end
                end
            end
        end
        summary();
    end
endmodule